// File: doc/BRIEF.md
# Serial-Bus Register Slave with Movable Device Address

This block sits on a two-wire serial bus as a slave and gives a bus master access to a bank of 8-bit registers. Every access goes through a stored pointer. A write transaction first loads the pointer. An optional second byte is then written to the register that the pointer selects. A read transaction returns the byte that the current pointer selects. The bus lines are sampled with the system clock, and the slave drives SDA only as an open-drain pull-down enable.

The 7-bit device address is built from two parts. The two low bits are taken from strap pins while reset is held. The five high bits start at a fixed value and can be rewritten through an internal address register that sits at a fixed pointer value. The register bank itself is outside the block. It is reached through a plain port: a pointer output, a write-data output, a one-cycle write strobe, and a read-data input.

Top module: `i2c_regslave`

## Requirements
- R1: After reset `sda_oe` and `reg_we` are 0 and `reg_addr` is 0x00. The device address is {5'b01011, strap_i sampled during reset}; with strap_i = 2'b10 it is 0x2E.
- R2: The first byte after START is the 7-bit address, MSB first, in bits [7:1], with the R/W bit in bit 0 (0 = write, 1 = read). If the address matches, the slave pulls SDA low in the ninth clock. If it does not match, the slave never drives SDA and changes no state until the next START.
- R3: A START (SDA falls while SCL is high) in any state, including mid-byte, restarts address reception. A STOP (SDA rises while SCL is high) releases SDA and returns the slave to idle.
- R4: In a write transaction the first data byte is acknowledged and loaded into the pointer, which appears on `reg_addr`.
- R5: A second data byte is acknowledged and written to the register at the pointer with a single-cycle `reg_we` pulse, carrying the byte on `reg_wdata`.
- R6: Bytes after the second in a write transaction are acknowledged and cause no write. The pointer does not auto-increment.
- R7: A read transaction drives the register at the current pointer MSB first, and a master NACK ends the read.
- R8: Pointer value 0x48 selects the internal address register. Reading it returns {1'b0, device address}. Writing it replaces only the five high address bits with data bits [6:2], keeps the strapped low bits, issues no `reg_we`, and takes effect from the next transaction.
- R9: The slave raises `sda_oe` only after it has detected a falling SCL edge.
- R10: A read transaction never produces a `reg_we` pulse; the direction is fixed by the R/W bit after START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset; strap pins are sampled while it is low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 2 | Pin straps for the two low address bits |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | 8 | Current pointer value, selects the bank register |
| reg_wdata | output | 8 | Data for a bank write |
| reg_we | output | 1 | One-cycle bank write strobe |
| reg_rdata | input | 8 | Bank read data for the register at `reg_addr` |

## Verification
A wrong bit counter or a wrong state shows up within one bit time as an acknowledge in the wrong clock, or as SDA being driven when the master owns the line. The bench catches this because it compares `sda_oe` against its own model of the bus ownership windows on every clock. A corrupted pointer or address register stays hidden until the next access. It then appears as a write landing in the wrong bank location, or as read data or an acknowledge that differs from the model, so every scenario ends by reading back through the bus. A write strobe outside the second data byte of a write transaction is flagged in the cycle it occurs.

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter logic [4:0] ADDR_HI_RST = 5'b01011,
  parameter logic [7:0] SADDR_PTR   = 8'h48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  st_t        state;
  logic [2:0] scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] shreg, ptr, wdata;
  logic [4:0] addr_hi;
  logic [1:0] strap_q, nbyte;
  logic       rw, oe, we;

  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire [6:0] dev_addr = {addr_hi, strap_q};
  wire [7:0] rd_byte  = (ptr == SADDR_PTR) ? {1'b0, dev_addr} : reg_rdata;
  wire [7:0] shifted  = {shreg[6:0], sda_q[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      ptr     <= '0;
      wdata   <= '0;
      addr_hi <= ADDR_HI_RST;
      strap_q <= strap_i;
      nbyte   <= '0;
      rw      <= 1'b0;
      oe      <= 1'b0;
      we      <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_det) begin
        state <= S_ADDR;
        cnt   <= '0;
        oe    <= 1'b0;
      end else if (stop_det) begin
        state <= S_IDLE;
        oe    <= 1'b0;
      end else begin
        case (state)
          S_ADDR:
            if (scl_rise) begin
              shreg <= shifted;
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (shreg[7:1] == dev_addr) begin
                oe    <= 1'b1;
                rw    <= shreg[0];
                nbyte <= '0;
                state <= S_AACK;
              end else begin
                state <= S_IDLE;
              end
            end
          S_AACK:
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                shreg <= rd_byte;
                oe    <= ~rd_byte[7];
                state <= S_RD;
              end else begin
                oe    <= 1'b0;
                state <= S_WR;
              end
            end
          S_WR:
            if (scl_rise) begin
              shreg <= shifted;
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              oe    <= 1'b1;
              state <= S_WACK;
              if (nbyte == 2'd0) begin
                ptr <= shreg;
              end else if (nbyte == 2'd1) begin
                if (ptr == SADDR_PTR) addr_hi <= shreg[6:2];
                else begin
                  we    <= 1'b1;
                  wdata <= shreg;
                end
              end
              if (nbyte != 2'd2) nbyte <= nbyte + 2'd1;
            end
          S_WACK:
            if (scl_fall) begin
              oe    <= 1'b0;
              cnt   <= '0;
              state <= S_WR;
            end
          S_RD:
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                oe    <= 1'b0;
                state <= S_RACK;
              end else begin
                shreg <= {shreg[6:0], 1'b0};
                oe    <= ~shreg[6];
              end
            end
          S_RACK:
            if (scl_rise) state <= sda_q[1] ? S_IDLE : S_AACK;
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = oe;
  assign reg_addr  = ptr;
  assign reg_wdata = wdata;
  assign reg_we    = we;

  AST_WE_SINGLE:     assert property (@(posedge clk) disable iff (!rst_n) we |=> !we);                          // R5
  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) $rose(oe) |-> !$past(scl_q[1]));      // R9
  AST_STOP_RELEASE:  assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> !oe);                    // R3
  AST_NO_WE_SADDR:   assert property (@(posedge clk) disable iff (!rst_n) we |-> ptr != SADDR_PTR);             // R8
  AST_READ_NO_WE:    assert property (@(posedge clk) disable iff (!rst_n) (rw && state == S_RD) |-> !we);       // R10

endmodule

// File: tb/test_i2c_regslave.sv
module test_i2c_regslave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic drive_ok = 1'b0, we_ok = 1'b0, done = 1'b0;
  int checks = 0, errors = 0, we_cnt = 0;
  wire sda_line = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  i2c_regslave i_i2c_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .strap_i(strap),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) if (reg_we) begin
    mem[reg_addr] <= reg_wdata;
    we_cnt <= we_cnt + 1;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-clock model of who may drive SDA (R2, R9) and when a write may occur (R10)
  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (sda_oe && !drive_ok) begin
      errors++;
      $display("FAIL R2 unexpected sda_oe actual=1 expected=0 at %0t", $time);
    end
    checks++;
    if (reg_we && !we_ok) begin
      errors++;
      $display("FAIL R10 unexpected reg_we actual=1 expected=0 at %0t", $time);
    end
  end

  task automatic hq; repeat (10) @(negedge clk); endtask

  task automatic bstart;
    m_sda = 1'b1; hq; m_scl = 1'b1; hq; m_sda = 1'b0; hq; m_scl = 1'b0; hq;
  endtask

  task automatic bstop;
    m_sda = 1'b0; hq; m_scl = 1'b1; hq; m_sda = 1'b1; hq;
  endtask

  task automatic send_bit(input logic b, input logic arm, input logic wa);
    m_sda = b; hq; m_scl = 1'b1; hq; hq;
    if (arm) begin drive_ok = 1'b1; we_ok = wa; end
    m_scl = 1'b0; hq;
  endtask

  task automatic ack_bit(output logic a, input logic keep);
    m_sda = 1'b1; hq; m_scl = 1'b1; hq; a = ~sda_line; hq; m_scl = 1'b0; hq;
    if (!keep) drive_ok = 1'b0;
    we_ok = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic wa, input logic keep, output logic a);
    for (int i = 7; i >= 0; i--) send_bit(b[i], i == 0, wa);
    ack_bit(a, keep);
  endtask

  task automatic read_byte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; hq; m_scl = 1'b1; hq; b[i] = sda_line; hq; m_scl = 1'b0; hq;
    end
    drive_ok = 1'b0;
    send_bit(nack, !nack, 1'b0);
  endtask

  task automatic wr_ptr_data(input logic [6:0] dev, input logic [7:0] p, input logic [7:0] d, input string req);
    logic a;
    bstart;
    send_byte({dev, 1'b0}, 1'b0, 1'b0, a); chk({req, " addr ack"}, {7'd0, a}, 8'd1);
    send_byte(p, 1'b0, 1'b0, a);           chk({req, " ptr ack"},  {7'd0, a}, 8'd1);
    send_byte(d, 1'b1, 1'b0, a);           chk({req, " data ack"}, {7'd0, a}, 8'd1);
    bstop;
  endtask

  task automatic rd_cur(input logic [6:0] dev, output logic [7:0] v, input string req);
    logic a;
    bstart;
    send_byte({dev, 1'b1}, 1'b0, 1'b1, a); chk({req, " read addr ack"}, {7'd0, a}, 8'd1);
    read_byte(v, 1'b1);
    bstop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] v;
    int wc;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 sda_oe after reset", {7'd0, sda_oe}, 8'd0);
    chk("R1 reg_we after reset", {7'd0, reg_we}, 8'd0);
    chk("R1 reg_addr after reset", reg_addr, 8'h00);

    wr_ptr_data(7'h2E, 8'h10, 8'hA5, "R5");
    chk("R4 pointer on reg_addr", reg_addr, 8'h10);
    chk("R5 bank write", mem[8'h10], 8'hA5);
    chk("R5 one write strobe", 8'(we_cnt), 8'd1);

    rd_cur(7'h2E, v, "R7");
    chk("R7 read data", v, 8'hA5);
    chk("R10 no write in read", 8'(we_cnt), 8'd1);

    bstart;
    send_byte({7'h2E, 1'b0}, 1'b0, 1'b0, a); chk("R4 addr ack", {7'd0, a}, 8'd1);
    send_byte(8'h20, 1'b0, 1'b0, a);         chk("R4 ptr ack", {7'd0, a}, 8'd1);
    bstop;
    chk("R4 pointer only", reg_addr, 8'h20);
    rd_cur(7'h2E, v, "R7");
    chk("R7 read preloaded", v, 8'h20 ^ 8'h5A);

    bstart;
    send_byte({7'h2C, 1'b0}, 1'b0, 1'b0, a); chk("R2 mismatch no ack", {7'd0, a}, 8'd0);
    send_byte(8'h60, 1'b0, 1'b0, a);         chk("R2 ignored byte no ack", {7'd0, a}, 8'd0);
    send_byte(8'hEE, 1'b0, 1'b0, a);
    bstop;
    chk("R2 pointer unchanged", reg_addr, 8'h20);
    chk("R2 no write", 8'(we_cnt), 8'd1);

    bstart;
    send_byte({7'h2E, 1'b0}, 1'b0, 1'b0, a);
    send_byte(8'h30, 1'b0, 1'b0, a);
    send_byte(8'h11, 1'b1, 1'b0, a);
    send_byte(8'h22, 1'b0, 1'b0, a);         chk("R6 third byte ack", {7'd0, a}, 8'd1);
    send_byte(8'h33, 1'b0, 1'b0, a);         chk("R6 fourth byte ack", {7'd0, a}, 8'd1);
    bstop;
    chk("R6 data kept", mem[8'h30], 8'h11);
    chk("R6 no increment", mem[8'h31], 8'h31 ^ 8'h5A);
    chk("R6 pointer fixed", reg_addr, 8'h30);
    chk("R6 single write", 8'(we_cnt), 8'd2);

    bstart;
    send_byte({7'h2E, 1'b0}, 1'b0, 1'b0, a);
    send_byte(8'h40, 1'b0, 1'b0, a);
    bstart;
    send_byte({7'h2E, 1'b1}, 1'b0, 1'b1, a); chk("R3 repeated start ack", {7'd0, a}, 8'd1);
    read_byte(v, 1'b1);
    bstop;
    chk("R3 repeated start read", v, 8'h40 ^ 8'h5A);

    bstart;
    send_byte({7'h2E, 1'b0}, 1'b0, 1'b0, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0, 1'b0);
    wr_ptr_data(7'h2E, 8'h50, 8'h77, "R3");
    chk("R3 abort mid-byte then write", mem[8'h50], 8'h77);

    wc = we_cnt;
    wr_ptr_data(7'h2E, 8'h48, 8'h15, "R8");
    chk("R8 no bank strobe", 8'(we_cnt), 8'(wc));
    chk("R8 bank untouched", mem[8'h48], 8'h48 ^ 8'h5A);
    bstart;
    send_byte({7'h2E, 1'b1}, 1'b0, 1'b0, a); chk("R8 old address rejected", {7'd0, a}, 8'd0);
    bstop;
    rd_cur(7'h16, v, "R8");
    chk("R8 readback address keeps straps", v, 8'h16);
    rd_cur(7'h16, v, "R1");
    chk("R1 strap bits fixed", {6'd0, v[1:0]}, 8'd2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule